// File: doc/BRIEF.md
# Per-Variable Bookkeeping Cells with Distributed Backtrack-Level Resolution

This block holds the per-variable state of a hardware satisfiability search engine. It contains one cell per variable, and each cell watches that variable's three-wire status bus: a positive line, a negative line and an implied flag. The first time the bus shows a definite value, the cell records that value, the current decision level, and whether the value came from a decision or from an implication. A cell's position in the array serves as the variable's tag. When the implied flag is first seen, the cell emits a pulse that lasts exactly one cycle, so the sequencer knows that new implications are still arriving.

During conflict analysis the sequencer raises a capture strobe. Every decision variable whose bus shows the "participates in the conflict" code emits the complement of its recorded value as a literal of the learned clause, together with a one-cycle write strobe.

The same participating cells also resolve the backtrack level. Each cell contributes bits to a shared OR bus, working from the most significant bit down, and withdraws once it finds itself outranked. The bus is registered and re-evaluated every cycle, so it reaches the maximum participating level within one cycle per level bit. Two clear commands use this level. A global refresh wipes every cell. An unwind wipes only the cells whose recorded level is above the resolved backtrack level.

Top module: `vcell_array`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs become zero on that edge: new_impl, learn_pos, learn_neg, learn_wr and bt_lvl.
- R2: If impl_i[v] is high at an edge and it has not been seen since the cell was last cleared, new_impl[v] is high for exactly the following cycle. Holding impl_i[v] high longer produces no further pulse.
- R3: The status code of variable v is {lit_i[v], litb_i[v]}. The code 10 means value 1 and 01 means value 0. At the first edge where the cell is empty and the code is 10 or 01, the cell records the value, cur_lvl and impl_i[v] (1 = implied, 0 = decision). Later bus changes leave the record untouched until the cell is cleared.
- R4: At an edge where capture_en is high, a cell takes part in the conflict if it holds a decision and its triplet {lit_i, litb_i, impl_i} equals 110. In the next cycle such a cell drives the complement of its recorded value: learn_pos[v]=1 for a recorded 0, learn_neg[v]=1 for a recorded 1. In that same cycle learn_wr is high, and it is high for that one cycle only.
- R5: At a capture edge, a cell with an implied record, a cell with no record, or a cell whose triplet is not 110 emits no literal. Such a cell also drops out of the backtrack-level search.
- R6: Once the set of participating cells has stayed unchanged for LVL_W edges, bt_lvl equals the largest recorded level among the participants. If there are no participants, bt_lvl is 0.
- R7: When refresh is high at an edge, every cell is cleared: its record, its pulse state and its participation. A later impl_i produces a new pulse, and bt_lvl returns to 0.
- R8: When unwind is high at an edge, only the cells whose recorded level is strictly greater than bt_lvl are cleared. A cleared cell re-records at the level current at its next definite bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lit_i | input | NVAR | Positive-value line of each variable |
| litb_i | input | NVAR | Negative-value line of each variable |
| impl_i | input | NVAR | Implied flag of each variable |
| cur_lvl | input | LVL_W | Current decision level |
| capture_en | input | 1 | Conflict-analysis capture strobe |
| refresh | input | 1 | Clear all cells |
| unwind | input | 1 | Clear cells above the backtrack level |
| new_impl | output | NVAR | One-cycle implication pulse per variable |
| learn_pos | output | NVAR | Learned literal: positive occurrence |
| learn_neg | output | NVAR | Learned literal: negated occurrence |
| learn_wr | output | 1 | Write strobe for the learned clause row |
| bt_lvl | output | LVL_W | Resolved backtrack level |

## Verification
The hardest situation to reach is an unwind that meets a settled backtrack level while cells above and below that level share the array. Those cells must include implied variables that show the conflict code but must not compete for the level. Directed stimulus builds such a case first: decisions at several levels, an implied variable, and a higher decision kept out of the conflict. It then captures, waits for the level to settle, unwinds and re-captures with a smaller set, so the bus also has to settle downward. A long random phase follows. It mixes legal triplets, captures, refreshes and unwinds, but issues an unwind only after the reference model reports a settled level.

// File: rtl/vcell_pkg.sv
// Shared types for the per-variable bookkeeping array.
// Assumes the two value lines of a variable are sampled together with its
// implied flag on the same clock edge.
package vcell_pkg;

    // Decoded view of the two value lines of one variable.
    typedef enum logic [1:0] {
        BUS_IDLE = 2'b00,
        BUS_ZERO = 2'b01,
        BUS_ONE  = 2'b10,
        BUS_BOTH = 2'b11
    } bus_code_e;

    // Map the positive and negative lines onto the bus code.
    function automatic bus_code_e decode_bus(input logic pos, input logic neg);
        return bus_code_e'({pos, neg});
    endfunction

endpackage

// File: rtl/vcell_pulse.sv
// Two-flop implication pulse generator.
// The first flop latches once the trigger is seen. The second follows it one
// cycle later and masks the output, so the pulse lasts exactly one cycle.
// Both flops stay set until a clear, so a held trigger gives one pulse only.
module vcell_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic trig,
    output logic pulse
);
    logic seen_q;
    logic mask_q;

    // Latch the first sighting of the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            seen_q <= 1'b0;
        else if (trig)
            seen_q <= 1'b1;
    end

    // Follow the first flop one cycle later to close the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            mask_q <= 1'b0;
        else
            mask_q <= seen_q;
    end

    assign pulse = seen_q & ~mask_q;
endmodule

// File: rtl/vcell_cell.sv
// Bookkeeping cell for one variable.
// It records the value, the level and the decision/implied kind on the first
// definite bus value. It marks conflict participation and emits the
// learned-clause literal on a capture. It drives its share of the backtrack
// level bus: a bit is driven only while no higher bit has found this cell
// outranked (own bit 0 where the bus shows 1).
// Assumes bus_lvl is the registered wired-OR of all cells' contributions.
module vcell_cell
    import vcell_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lit,
    input  logic             litb,
    input  logic             impl,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             capture_en,
    input  logic             refresh,
    input  logic             unwind,
    input  logic [LVL_W-1:0] bus_lvl,
    output logic             new_impl,
    output logic             lit_pos,
    output logic             lit_neg,
    output logic             wr,
    output logic [LVL_W-1:0] contrib
);
    bus_code_e        code;
    logic             held_q;
    logic             val_q;
    logic             kind_imp_q;
    logic [LVL_W-1:0] lvl_q;
    logic             part_q;
    logic             wr_q;
    logic             clr;
    logic             joins;

    // Decode the value lines once for all users.
    assign code = decode_bus(lit, litb);

    // A cell is cleared by refresh, or by unwind when its level is above the bus.
    assign clr = refresh | (unwind & held_q & (lvl_q > bus_lvl));

    // The cell joins a conflict when it holds a decision and shows 110.
    assign joins = capture_en & held_q & ~kind_imp_q & (code == BUS_BOTH) & ~impl;

    // Record the first definite value together with its level and kind.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            held_q     <= 1'b0;
            val_q      <= 1'b0;
            kind_imp_q <= 1'b0;
            lvl_q      <= '0;
        end else if (!held_q && (code == BUS_ZERO || code == BUS_ONE)) begin
            held_q     <= 1'b1;
            val_q      <= (code == BUS_ONE);
            kind_imp_q <= impl;
            lvl_q      <= cur_lvl;
        end
    end

    // Participation is re-decided on every capture and kept until a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            part_q <= 1'b0;
        else if (capture_en)
            part_q <= joins;
    end

    // One-cycle write request following a capture that this cell joined.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            wr_q <= 1'b0;
        else
            wr_q <= joins;
    end

    // Implication pulse from the two-flop edge detector.
    vcell_pulse i_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .trig  (impl),
        .pulse (new_impl)
    );

    // The learned literal is the complement of the recorded value.
    assign lit_pos = wr_q & ~val_q;
    assign lit_neg = wr_q &  val_q;
    assign wr      = wr_q;

    // MSB-first contention: stop driving once outranked on a higher bit.
    always_comb begin
        logic lost;
        lost    = 1'b0;
        contrib = '0;
        for (int k = LVL_W - 1; k >= 0; k--) begin
            contrib[k] = part_q & lvl_q[k] & ~lost;
            lost       = lost | (~lvl_q[k] & bus_lvl[k]);
        end
    end
endmodule

// File: rtl/vcell_btres.sv
// Backtrack-level bus: the wired-OR of every cell's contribution, registered
// once per cycle. The cells re-evaluate against the registered value, so the
// bus gains one correct bit per cycle from the MSB down. It settles to the
// maximum participating level within LVL_W cycles from any start value.
module vcell_btres #(
    parameter int NVAR  = 6,
    parameter int LVL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NVAR*LVL_W-1:0] contrib_flat,
    output logic [LVL_W-1:0]      bus_lvl
);
    logic [LVL_W-1:0] or_all;

    // OR every cell's contribution together.
    always_comb begin
        or_all = '0;
        for (int v = 0; v < NVAR; v++)
            or_all = or_all | contrib_flat[v*LVL_W +: LVL_W];
    end

    // Register the bus so that each resolution step takes one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_lvl <= '0;
        else
            bus_lvl <= or_all;
    end
endmodule

// File: rtl/vcell_array.sv
// Array of per-variable bookkeeping cells that share one backtrack-level bus
// and one learned-clause write strobe.
// Assumes the sequencer issues unwind only after the level bus has settled.
module vcell_array #(
    parameter int NVAR  = 6,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NVAR-1:0]  lit_i,
    input  logic [NVAR-1:0]  litb_i,
    input  logic [NVAR-1:0]  impl_i,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             capture_en,
    input  logic             refresh,
    input  logic             unwind,
    output logic [NVAR-1:0]  new_impl,
    output logic [NVAR-1:0]  learn_pos,
    output logic [NVAR-1:0]  learn_neg,
    output logic             learn_wr,
    output logic [LVL_W-1:0] bt_lvl
);
    localparam int BUS_BITS = NVAR * LVL_W;

    logic [BUS_BITS-1:0] contrib_flat;
    logic [NVAR-1:0]     wr_vec;

    // One cell per variable; the position in the array is the variable tag.
    for (genvar v = 0; v < NVAR; v++) begin : g_cell
        vcell_cell #(.LVL_W(LVL_W)) i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .lit        (lit_i[v]),
            .litb       (litb_i[v]),
            .impl       (impl_i[v]),
            .cur_lvl    (cur_lvl),
            .capture_en (capture_en),
            .refresh    (refresh),
            .unwind     (unwind),
            .bus_lvl    (bt_lvl),
            .new_impl   (new_impl[v]),
            .lit_pos    (learn_pos[v]),
            .lit_neg    (learn_neg[v]),
            .wr         (wr_vec[v]),
            .contrib    (contrib_flat[v*LVL_W +: LVL_W])
        );
    end

    // Shared level bus resolved from every cell's contribution.
    vcell_btres #(.NVAR(NVAR), .LVL_W(LVL_W)) i_btres (
        .clk          (clk),
        .rst_n        (rst_n),
        .contrib_flat (contrib_flat),
        .bus_lvl      (bt_lvl)
    );

    // The clause row is written when any cell emits a literal.
    assign learn_wr = |wr_vec;
endmodule

// File: rtl/vcell_array_chk.sv
// Checker for vcell_array, attached with a bind statement.
module vcell_array_chk #(
    parameter int NVAR  = 6,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NVAR-1:0]  lit_i,
    input logic [NVAR-1:0]  litb_i,
    input logic [NVAR-1:0]  impl_i,
    input logic             capture_en,
    input logic             refresh,
    input logic [NVAR-1:0]  new_impl,
    input logic [NVAR-1:0]  learn_pos,
    input logic [NVAR-1:0]  learn_neg,
    input logic             learn_wr
);
    // R2: a pulse never lasts two cycles on the same variable.
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|new_impl) |=> ((new_impl & $past(new_impl)) == '0));

    // R2: a pulse only follows an implied flag seen on the previous edge.
    a_r2_caused_by_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((new_impl & ~$past(impl_i)) == '0));

    // R4: the write strobe only follows a capture edge.
    a_r4_wr_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        learn_wr |-> $past(capture_en));

    // R4: a variable never appears in both polarities at once.
    a_r4_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        ((learn_pos & learn_neg) == '0));

    // R5: literals only come from variables that showed 110 at the capture.
    a_r5_only_conflict_code: assert property (@(posedge clk) disable iff (!rst_n)
        (((learn_pos | learn_neg) & ~($past(lit_i) & $past(litb_i) & ~$past(impl_i))) == '0));

    // R7: right after a refresh nothing pulses and nothing is written.
    a_r7_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (new_impl == '0 && !learn_wr));
endmodule

bind vcell_array vcell_array_chk #(.NVAR(NVAR), .LVL_W(LVL_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lit_i      (lit_i),
    .litb_i     (litb_i),
    .impl_i     (impl_i),
    .capture_en (capture_en),
    .refresh    (refresh),
    .new_impl   (new_impl),
    .learn_pos  (learn_pos),
    .learn_neg  (learn_neg),
    .learn_wr   (learn_wr)
);

// File: tb/test_vcell_array.sv
module test_vcell_array;
    localparam int NVAR  = 6;
    localparam int LVL_W = 4;
    localparam int TCLK  = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NVAR-1:0]  lit_i = '0, litb_i = '0, impl_i = '0;
    logic [LVL_W-1:0] cur_lvl = '0;
    logic             capture_en = 1'b0, refresh = 1'b0, unwind = 1'b0;
    logic [NVAR-1:0]  new_impl, learn_pos, learn_neg;
    logic             learn_wr;
    logic [LVL_W-1:0] bt_lvl;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    string phase = "R1";

    vcell_array #(.NVAR(NVAR), .LVL_W(LVL_W)) i_vcell_array (
        .clk(clk), .rst_n(rst_n), .lit_i(lit_i), .litb_i(litb_i), .impl_i(impl_i),
        .cur_lvl(cur_lvl), .capture_en(capture_en), .refresh(refresh), .unwind(unwind),
        .new_impl(new_impl), .learn_pos(learn_pos), .learn_neg(learn_neg),
        .learn_wr(learn_wr), .bt_lvl(bt_lvl)
    );

    always #(TCLK/2) clk = ~clk;

    // Reference model state, one entry per variable.
    bit m_held[NVAR], m_val[NVAR], m_kind[NVAR], m_a[NVAR], m_b[NVAR];
    bit m_part[NVAR], m_wr[NVAR], m_lp[NVAR], m_ln[NVAR];
    int m_lvl[NVAR];
    int m_cnt = LVL_W;

    function automatic int model_max();
        int mx = 0;
        for (int v = 0; v < NVAR; v++)
            if (m_part[v] && m_lvl[v] > mx) mx = m_lvl[v];
        return mx;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [phase %s] actual %0d expected %0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    // Behavioural model advanced on every rising edge.
    always @(posedge clk) begin
        int mx;
        bit changed;
        mx = model_max();
        changed = 1'b0;
        if (!rst_n) begin
            for (int v = 0; v < NVAR; v++) begin
                m_held[v] = 0; m_val[v] = 0; m_kind[v] = 0; m_a[v] = 0; m_b[v] = 0;
                m_part[v] = 0; m_wr[v] = 0; m_lp[v] = 0; m_ln[v] = 0; m_lvl[v] = 0;
            end
            m_cnt = LVL_W;
        end else begin
            for (int v = 0; v < NVAR; v++) begin
                bit clr, joins, was;
                was = m_part[v];
                clr = refresh || (unwind && m_held[v] && m_lvl[v] > mx);
                joins = capture_en && lit_i[v] && litb_i[v] && !impl_i[v] && m_held[v] && !m_kind[v];
                if (clr) begin
                    m_held[v] = 0; m_a[v] = 0; m_b[v] = 0; m_part[v] = 0;
                    m_wr[v] = 0; m_lp[v] = 0; m_ln[v] = 0;
                end else begin
                    m_wr[v] = joins;
                    m_lp[v] = joins && !m_val[v];
                    m_ln[v] = joins && m_val[v];
                    if (capture_en) m_part[v] = joins;
                    m_b[v] = m_a[v];
                    if (impl_i[v]) m_a[v] = 1;
                    if (!m_held[v] && (lit_i[v] != litb_i[v])) begin
                        m_held[v] = 1; m_val[v] = lit_i[v]; m_kind[v] = impl_i[v];
                        m_lvl[v] = int'(cur_lvl);
                    end
                end
                if (was != m_part[v]) changed = 1'b1;
            end
            if (changed) m_cnt = 0;
            else if (m_cnt < LVL_W) m_cnt++;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            bit [NVAR-1:0] e_ni, e_lp, e_ln;
            bit e_wr;
            e_wr = 0;
            for (int v = 0; v < NVAR; v++) begin
                e_ni[v] = m_a[v] && !m_b[v];
                e_lp[v] = m_lp[v];
                e_ln[v] = m_ln[v];
                e_wr = e_wr | m_wr[v];
            end
            check("R2 new_impl", int'(new_impl), int'(e_ni));
            check("R4 learn_pos", int'(learn_pos), int'(e_lp));
            check("R4 learn_neg", int'(learn_neg), int'(e_ln));
            check("R4 learn_wr", int'(learn_wr), int'(e_wr));
            if (m_cnt >= LVL_W) check("R6 bt_lvl", int'(bt_lvl), model_max());
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_var(int v, bit p, bit n, bit im);
        lit_i[v] = p; litb_i[v] = n; impl_i[v] = im;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d cycles expected fewer", 50000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        step(2);
        phase = "R1";
        check("R1 new_impl", int'(new_impl), 0);
        check("R1 learn_wr", int'(learn_wr), 0);
        check("R1 learn_pos/neg", int'(learn_pos | learn_neg), 0);
        check("R1 bt_lvl", int'(bt_lvl), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R3: decisions at several levels, one implied variable.
        phase = "R3";
        cur_lvl = 2; set_var(1, 0, 1, 0); step();
        cur_lvl = 5; set_var(2, 1, 0, 0); step();
        cur_lvl = 9; set_var(3, 1, 0, 0); step();
        phase = "R2";
        set_var(0, 0, 1, 1); step();
        check("R2 pulse rises", int'(new_impl), 6'b000001);
        step();
        check("R2 pulse ends", int'(new_impl), 0);
        step();
        check("R2 held flag no repeat", int'(new_impl), 0);
        phase = "R3";
        cur_lvl = 12; set_var(4, 1, 0, 0); step();
        set_var(2, 0, 1, 0); step();   // later change must be ignored
        set_var(2, 1, 0, 0);

        // R4 / R5: capture with var0 implied but showing 110, var4 outside.
        phase = "R4";
        for (int v = 0; v < 4; v++) set_var(v, 1, 1, 0);
        capture_en = 1'b1; step(); capture_en = 1'b0;
        check("R4 positive literal var1", int'(learn_pos), 6'b000010);
        check("R3 recorded value kept var2", int'(learn_neg[2]), 1);
        check("R4 negated literals", int'(learn_neg), 6'b001100);
        check("R4 write strobe", int'(learn_wr), 1);
        check("R5 implied var0 silent", int'(learn_pos[0] | learn_neg[0]), 0);
        step();
        check("R4 strobe one cycle", int'(learn_wr), 0);
        phase = "R6";
        step(LVL_W);
        check("R6 max level", int'(bt_lvl), 9);

        // R8: unwind clears only var4 (level 12 > 9).
        phase = "R8";
        unwind = 1'b1; step(); unwind = 1'b0;
        cur_lvl = 1; set_var(4, 0, 1, 0); step();
        set_var(4, 1, 1, 0); set_var(2, 0, 0, 0); set_var(3, 0, 0, 0);
        capture_en = 1'b1; step(); capture_en = 1'b0;
        check("R8 var4 re-recorded value 0", int'(learn_pos), 6'b010010);
        check("R8 var2 var3 kept", int'(learn_neg), 0);
        step(LVL_W);
        check("R8 level settles down", int'(bt_lvl), 2);

        // R7: refresh wipes everything and rearms the pulse.
        phase = "R7";
        refresh = 1'b1; step(); refresh = 1'b0;
        lit_i = '0; litb_i = '0; impl_i = '0;
        step(LVL_W);
        check("R7 level cleared", int'(bt_lvl), 0);
        set_var(0, 1, 0, 1); step();
        check("R7 pulse rearmed", int'(new_impl), 6'b000001);
        step();

        // Random phase covering all requirements together.
        phase = "R6";
        for (int c = 0; c < 600; c++) begin
            int r;
            for (int v = 0; v < NVAR; v++) begin
                r = $urandom_range(0, 6);
                case (r)
                    0: set_var(v, 0, 0, 0);
                    1: set_var(v, 0, 1, 0);
                    2: set_var(v, 1, 0, 0);
                    3: set_var(v, 0, 1, 1);
                    4: set_var(v, 1, 0, 1);
                    5: set_var(v, 1, 1, 0);
                    default: set_var(v, 1, 1, 1);
                endcase
            end
            cur_lvl = LVL_W'($urandom_range(0, (1 << LVL_W) - 1));
            r = $urandom_range(0, 39);
            capture_en = (r < 7);
            refresh = (r == 39);
            unwind = (r >= 30 && r < 36 && m_cnt >= LVL_W);
            step();
        end
        capture_en = 1'b0; refresh = 1'b0; unwind = 1'b0;
        step(LVL_W + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule